// File: doc/BRIEF.md
# Tag Memory Compare and Match Unit

This block is a small synchronous word memory with a built-in equality comparator, meant to hold cache tags. On every clock edge it accepts one command, formed from a select, a write strobe and a data-enable. The command is one of five kinds:

- **read**: returns a stored word.
- **write**: stores the word on the input bus.
- **compare**: reads a stored word internally and checks it against the word on the input bus. The match flag carries the result, and the data outputs stay undriven unless the output enable is raised.
- **fill-write**: stores the word captured by the last data-enabled cycle, without looking at the input bus.
- **deselect**: does nothing.

The usual use is a tag lookup. The controller compares; on a miss it fills the same address with the tag it just compared, and the next compare of that tag hits.

Every output follows a mode pin. In flow-through mode a result appears after the edge that took the command. In pipeline mode it appears one edge later, from an extra register stage. Two enables gate the two output drivers directly, without a clock: one for the read data, one for the match flag. The drive enables are ports, so the chip level can build the tri-state pads.

The unit has no back-pressure. It takes a command on every edge and produces a result a fixed number of edges later, so a stream source must treat it as always ready.

Top module: `tagcmp_unit`

## Requirements
- R1: After reset, with no command yet taken, `dq_oe_o` is 0 and `match_o` is 1.
- R2: A write (`sel_i`=1, `wr_i`=1, `den_i`=1) stores `din_i` at `addr_i` and also loads `din_i` into the captured-data register.
- R3: A read (`sel_i`=1, `wr_i`=0, `den_i`=0) presents the word stored at `addr_i` on `dq_o`. `dq_oe_o` is 1 when `oe_i`=1.
- R4: A compare (`sel_i`=1, `wr_i`=0, `den_i`=1) loads `din_i` into the captured-data register. `match_o` is then 1 exactly when all DATA_W bits of the word stored at `addr_i` equal `din_i`, and 0 otherwise.
- R5: The captured-data register changes only in a selected cycle with `den_i`=1. A fill-write (`sel_i`=1, `wr_i`=1, `den_i`=0) stores that register's contents at `addr_i` and ignores `din_i`.
- R6: For every result that does not come from a compare, `match_o` is 1.
- R7: `dq_oe_o` is 0 whenever `oe_i` is 0, and `match_oe_o` equals `moe_i`. Both follow their enable within the same cycle, with no clock edge needed.
- R8: With `pipe_i`=0, results are visible after the edge that took the command. With `pipe_i`=1, results are visible one edge later.
- R9: A deselected cycle (`sel_i`=0) changes neither the array nor the captured-data register, and its result has `dq_oe_o`=0. A write or fill-write result also has `dq_oe_o`=0.
- R10: A compare miss, then a fill-write to the same address, then a compare of the same word gives a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all commands are taken on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the control and output registers (not the array) |
| sel_i | input | 1 | Select; 1 takes a command this edge |
| wr_i | input | 1 | 1 = write or fill-write, 0 = read or compare |
| den_i | input | 1 | Data-enable; 1 loads `din_i` into the captured-data register |
| oe_i | input | 1 | Asynchronous read-data drive enable, active high |
| moe_i | input | 1 | Asynchronous match drive enable, active high |
| pipe_i | input | 1 | 1 = pipeline latency, 0 = flow-through latency |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Input data / compare word |
| dq_o | output | DATA_W | Read data |
| dq_oe_o | output | 1 | Drive enable for `dq_o` |
| match_o | output | 1 | Match flag (1 = hit, or no compare) |
| match_oe_o | output | 1 | Drive enable for `match_o` |

## Verification
The hardest case to reach from the ports is a fill-write that stores a word different from the one on the input bus at that moment. That needs an earlier data-enabled cycle to leave a known value in the captured-data register, and then a cycle that presents unrelated data with data-enable low. The stimulus mixes writes, fill-writes, reads, compares and deselected cycles with deliberately unrelated bus data, over a pool of only eight addresses. It also feeds compare words taken half the time from the bench's own copy of the array, so that hits, misses and fill-writes hit the same addresses often. Directed sequences cover the miss-fill-hit flow in both latency modes and the enables being toggled between edges.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;

  typedef enum logic [2:0] {
    TC_IDLE  = 3'd0,
    TC_READ  = 3'd1,
    TC_CMP   = 3'd2,
    TC_WRITE = 3'd3,
    TC_FILL  = 3'd4
  } tc_op_e;

  function automatic tc_op_e tc_decode(input logic sel, input logic wr, input logic den);
    tc_op_e op;
    if (!sel)          op = TC_IDLE;
    else if (wr && den) op = TC_WRITE;
    else if (wr)       op = TC_FILL;
    else if (den)      op = TC_CMP;
    else               op = TC_READ;
    return op;
  endfunction

endpackage

// File: rtl/tagcmp_decode.sv
module tagcmp_decode
  import tagcmp_pkg::*;
(
  input  logic sel_i,
  input  logic wr_i,
  input  logic den_i,
  output logic load_din_o,
  output logic write_o,
  output logic use_bus_o,
  output logic read_o,
  output logic cmp_o
);

  tc_op_e op;

  always_comb begin
    op         = tc_decode(sel_i, wr_i, den_i);
    load_din_o = (op == TC_WRITE) || (op == TC_CMP);
    write_o    = (op == TC_WRITE) || (op == TC_FILL);
    use_bus_o  = (op == TC_WRITE);
    read_o     = (op == TC_READ) || (op == TC_CMP);
    cmp_o      = (op == TC_CMP);
  end

endmodule

// File: rtl/tagcmp_array.sv
module tagcmp_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/tagcmp_compare.sv
module tagcmp_compare #(
  parameter int DATA_W = 18
) (
  input  logic              active_i,
  input  logic [DATA_W-1:0] stored_i,
  input  logic [DATA_W-1:0] probe_i,
  output logic              match_o
);

  logic [DATA_W-1:0] bit_eq;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign bit_eq[g] = ~(stored_i[g] ^ probe_i[g]);
  end

  assign match_o = active_i ? (&bit_eq) : 1'b1;

endmodule

// File: rtl/tagcmp_outstage.sv
module tagcmp_outstage #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_i,
  input  logic [DATA_W-1:0] fdata_i,
  input  logic              frd_i,
  input  logic              fmatch_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_o,
  output logic              match_o
);

  logic [DATA_W-1:0] pdata_q;
  logic              prd_q;
  logic              pmatch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdata_q  <= '0;
      prd_q    <= 1'b0;
      pmatch_q <= 1'b1;
    end else begin
      pdata_q  <= fdata_i;
      prd_q    <= frd_i;
      pmatch_q <= fmatch_i;
    end
  end

  assign data_o  = pipe_i ? pdata_q  : fdata_i;
  assign rd_o    = pipe_i ? prd_q    : frd_i;
  assign match_o = pipe_i ? pmatch_q : fmatch_i;

endmodule

// File: rtl/tagcmp_unit.sv
module tagcmp_unit #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              den_i,
  input  logic              oe_i,
  input  logic              moe_i,
  input  logic              pipe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              match_o,
  output logic              match_oe_o
);

  logic              load_din, do_write, use_bus, do_read, do_cmp;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              rd_q, cmp_q;
  logic [DATA_W-1:0] wdata, rdata, out_data;
  logic              flow_match, out_rd;

  tagcmp_decode u_dec (
    .sel_i(sel_i), .wr_i(wr_i), .den_i(den_i),
    .load_din_o(load_din), .write_o(do_write), .use_bus_o(use_bus),
    .read_o(do_read), .cmp_o(do_cmp)
  );

  // Captured-data register and command stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      din_q  <= '0;
      rd_q   <= 1'b0;
      cmp_q  <= 1'b0;
    end else begin
      addr_q <= addr_i;
      rd_q   <= do_read;
      cmp_q  <= do_cmp;
      if (load_din) din_q <= din_i;
    end
  end

  // fill-write stores the previously captured word
  assign wdata = use_bus ? din_i : din_q;

  tagcmp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we_i(do_write), .waddr_i(addr_i), .wdata_i(wdata),
    .raddr_i(addr_q), .rdata_o(rdata)
  );

  tagcmp_compare #(.DATA_W(DATA_W)) u_cmp (
    .active_i(cmp_q), .stored_i(rdata), .probe_i(din_q), .match_o(flow_match)
  );

  tagcmp_outstage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_i(pipe_i),
    .fdata_i(rdata), .frd_i(rd_q), .fmatch_i(flow_match),
    .data_o(out_data), .rd_o(out_rd), .match_o(match_o)
  );

  assign dq_o       = out_data;
  assign dq_oe_o    = oe_i & out_rd;
  assign match_oe_o = moe_i;

endmodule

// File: rtl/tagcmp_checker.sv
module tagcmp_checker #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              wr_i,
  input logic              den_i,
  input logic              oe_i,
  input logic              pipe_i,
  input logic              dq_oe_o,
  input logic              match_o,
  input logic              flow_match,
  input logic [DATA_W-1:0] din_q
);

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  AST_DQ_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |-> !dq_oe_o); // R7

  AST_MATCH_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !pipe_i && $past(!(sel_i && !wr_i && den_i))) |-> match_o); // R6

  AST_NO_DRIVE_NONREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !pipe_i && $past(!(sel_i && !wr_i))) |-> !dq_oe_o); // R9

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(!(sel_i && den_i))) |-> $stable(din_q)); // R5

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && pipe_i && $past(pipe_i)) |-> (match_o == $past(flow_match))); // R8

endmodule

bind tagcmp_unit tagcmp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i), .den_i(den_i),
  .oe_i(oe_i), .pipe_i(pipe_i), .dq_oe_o(dq_oe_o), .match_o(match_o),
  .flow_match(flow_match), .din_q(din_q)
);

// File: tb/tagcmp_unit_bench.sv
module tagcmp_unit_bench;

  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel = 0, wr = 0, den = 0, oe = 0, moe = 1, pipe = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o, match_o, match_oe_o;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem_m [1<<AW];
  logic [DW-1:0] dreg_m = '0;

  always #4 clk = ~clk;

  tagcmp_unit #(.ADDR_W(AW), .DATA_W(DW)) u_tagcmp_unit (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_i(wr), .den_i(den),
    .oe_i(oe), .moe_i(moe), .pipe_i(pipe), .addr_i(addr), .din_i(din),
    .dq_o(dq_o), .dq_oe_o(dq_oe_o), .match_o(match_o), .match_oe_o(match_oe_o)
  );

  function automatic logic exp_match(input logic cmp, input logic [DW-1:0] stored,
                                     input logic [DW-1:0] probe);
    return cmp ? (stored == probe) : 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic s, input logic w, input logic d,
                         input logic [AW-1:0] a, input logic [DW-1:0] x,
                         input logic oe_v, input string tag);
    logic rd, cm;
    logic [DW-1:0] expd;
    logic em;
    @(negedge clk);
    sel = s; wr = w; den = d; addr = a; din = x; oe = oe_v;
    rd = s && !w;
    cm = rd && d;
    if (s && w) mem_m[a] = d ? x : dreg_m;
    if (s && d) dreg_m = x;
    expd = mem_m[a];
    em   = exp_match(cm, mem_m[a], x);
    @(posedge clk);
    if (pipe) begin
      @(negedge clk);
      sel = 0; wr = 0; den = 0;
      @(posedge clk);
    end
    #2;
    chk({tag, " dq_oe"}, 32'(dq_oe_o), 32'(oe_v && rd));
    if (rd) chk({tag, " dq"}, 32'(dq_o), 32'(expd));
    chk({tag, " match"}, 32'(match_o), 32'(em));
  endtask

  task automatic miss_fill_hit(input logic [AW-1:0] a);
    logic [DW-1:0] tagw;
    tagw = mem_m[a] ^ 18'h2A5A5;
    run_cmd(1, 0, 1, a, tagw, 0, "R4 miss");
    run_cmd(1, 1, 0, a, ~tagw, 0, "R5 fill");
    run_cmd(1, 0, 1, a, tagw, 0, "R10 hit");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    oe = 1;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset dq_oe", 32'(dq_oe_o), 32'd0);
    chk("R1 reset match", 32'(match_o), 32'd1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk("R1 after reset match", 32'(match_o), 32'd1);
    chk("R1 after reset dq_oe", 32'(dq_oe_o), 32'd0);

    // fill the address pool
    for (int i = 0; i < 8; i++) run_cmd(1, 1, 1, AW'(i), DW'(18'h01111 * (i + 1)), 1, "R2 write");
    for (int i = 0; i < 8; i++) run_cmd(1, 0, 0, AW'(i), DW'($urandom), 1, "R3 read");

    // async enables (R7)
    run_cmd(1, 0, 0, 6'd3, 18'h0, 1, "R3 read before oe");
    oe = 0; #1 chk("R7 oe off", 32'(dq_oe_o), 32'd0);
    oe = 1; #1 chk("R7 oe on", 32'(dq_oe_o), 32'd1);
    moe = 0; #1 chk("R7 moe off", 32'(match_oe_o), 32'd0);
    moe = 1; #1 chk("R7 moe on", 32'(match_oe_o), 32'd1);

    // deselect keeps array and captured register (R9, R5)
    run_cmd(1, 1, 1, 6'd4, 18'h3C3C3, 1, "R2 write");
    run_cmd(0, 1, 1, 6'd4, 18'h00F0F, 1, "R9 deselect");
    run_cmd(1, 0, 0, 6'd4, 18'h11111, 1, "R9 read after deselect");
    run_cmd(1, 1, 0, 6'd5, 18'h22222, 1, "R5 fill");
    run_cmd(1, 0, 0, 6'd5, 18'h0, 1, "R5 read filled");
    run_cmd(1, 0, 1, 6'd5, 18'h3C3C3, 1, "R4 compare hit");
    run_cmd(1, 0, 1, 6'd5, 18'h3C3C2, 1, "R4 compare one-bit miss");

    miss_fill_hit(6'd2);
    pipe = 1;
    miss_fill_hit(6'd6);
    run_cmd(1, 0, 0, 6'd6, 18'h0, 1, "R8 pipeline read");
    pipe = 0;

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] x;
      int r;
      if (i == 200) pipe = 1;
      a = AW'($urandom % 8);
      x = DW'($urandom);
      r = int'($urandom % 6);
      case (r)
        0: run_cmd(1, 1, 1, a, x, 1'($urandom), "R2 rnd write");
        1: run_cmd(1, 1, 0, a, x, 1'($urandom), "R5 rnd fill");
        2: run_cmd(1, 0, 0, a, x, 1'($urandom), "R3 rnd read");
        3: run_cmd(1, 0, 1, a, ($urandom % 2) ? mem_m[a] : x, 1'($urandom), "R4 rnd compare");
        4: run_cmd(0, 1'($urandom), 1'($urandom), a, x, 1'($urandom), "R9 rnd deselect");
        default: run_cmd(1, 0, 1, a, x, 0, "R6 rnd compare miss");
      endcase
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule